// File: doc/BRIEF.md
# Decimal-Capable Add-With-Carry Unit

This unit performs the 8-bit add-with-carry operation of a classic accumulator-style processor. It has two arithmetic modes. In binary mode it adds two's-complement or unsigned bytes. In decimal mode it treats each byte as two packed BCD digits and corrects each digit. A decimal-mode input selects the mode for each operation. The unit returns the byte result and the carry, overflow, zero and negative flags.

Operation is driven by a one-cycle start strobe. On the clock edge that samples the start strobe, the unit captures the accumulator, operand, carry-in and mode. On the following edge it presents the result and all four flags together, with a one-cycle valid pulse. The outputs then hold until another operation completes or reset is applied.

In decimal mode the flags follow fixed rules that come from how the digit correction works:
- Zero and negative always come from the uncorrected binary sum.
- Overflow comes from the high-digit sum taken before that digit is corrected.

Digit values from 10 to 15 are not rejected. They pass through the same arithmetic, so every input pattern gives a defined output.

Top module: `dec_adc_unit`

## Requirements
- R1: With the decimal input low, `result` is (acc + operand + carryIn) mod 256, and `carryOut` is 1 exactly when that full sum exceeds 255.
- R2: With the decimal input low, `overflowOut` is 1 exactly when acc and operand have equal bit 7 and `result` bit 7 differs from it. This is the same as the signed sum lying outside -128..127.
- R3: With the decimal input high, the low digit sum is L = acc[3:0] + operand[3:0] + carryIn. If L >= 10, then 10 is subtracted from L and 1 is carried into the high digit. `result[3:0]` is the low 4 bits of the corrected L.
- R4: With the decimal input high, the high digit sum is H = acc[7:4] + operand[7:4] + the low-digit carry. If H >= 10, `carryOut` is 1 and `result[7:4]` is the low 4 bits of H - 10. Otherwise `carryOut` is 0 and `result[7:4]` is H[3:0].
- R5: With the decimal input high, `overflowOut` is 1 exactly when acc[7] equals operand[7] and operand[7] differs from bit 3 of H. H here is the uncorrected high digit sum from R4.
- R6: In both modes, `zeroOut` is 1 exactly when (acc + operand + carryIn) mod 256 is 0, and `negativeOut` is bit 7 of that binary sum.
- R7: Digit values from 10 to 15 in decimal mode follow R3 to R6 with no special case, for all 256 x 256 operand pairs.
- R8: If `start` is sampled high at edge k, then `validOut` is high for exactly the cycle after edge k+1 and carries that operation's results. `validOut` is never high without such a start.
- R9: While no operation completes, `result` and all four flags keep their values, even when the data inputs change with `start` low.
- R10: A synchronous active-high `rst` clears `result`, all flags and `validOut` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for one operation |
| accIn | input | 8 | Accumulator value |
| operandIn | input | 8 | Operand value |
| carryIn | input | 1 | Carry into the addition |
| decimalIn | input | 1 | 1 selects packed-BCD mode |
| result | output | 8 | Sum byte |
| carryOut | output | 1 | Carry flag |
| overflowOut | output | 1 | Overflow flag |
| zeroOut | output | 1 | Zero flag |
| negativeOut | output | 1 | Negative flag |
| validOut | output | 1 | One-cycle pulse marking new results |

## Verification
Every result and all four flags are due together, two rising edges after the driver raises `start` on a falling edge. The first edge captures the inputs and the second registers the outputs.

The driver stamps each expected item with the cycle count at issue. The monitor samples only on falling edges when `validOut` is high. It checks that exactly two edges have passed and that the values match the reference computed from the requirement rules.

Falling edges with no pending operation are checked for a silent `validOut` and for held outputs.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int DIGIT_W = 4;
  localparam int DIGIT_RADIX = 10;

  typedef struct packed {
    logic capture;
    logic present;
  } adcStrobes_t;

  typedef struct packed {
    logic carry;
    logic overflow;
    logic zero;
    logic negative;
  } adcFlags_t;
endpackage

// File: rtl/adc_digit_cell.sv
module adc_digit_cell
  import adc_pkg::*;
(
  input  logic [DIGIT_W-1:0] digA,
  input  logic [DIGIT_W-1:0] digB,
  input  logic               digCin,
  output logic [DIGIT_W-1:0] rawLow,
  output logic [DIGIT_W-1:0] adjDigit,
  output logic               digCout
);
  localparam int SUM_W = DIGIT_W + 1;

  logic [SUM_W-1:0] digSum;
  logic [SUM_W-1:0] corrected;

  always_comb begin
    digSum    = SUM_W'(digA) + SUM_W'(digB) + SUM_W'(digCin);
    digCout   = (digSum >= SUM_W'(DIGIT_RADIX));
    corrected = digCout ? (digSum - SUM_W'(DIGIT_RADIX)) : digSum;
    rawLow    = digSum[DIGIT_W-1:0];
    adjDigit  = corrected[DIGIT_W-1:0];
  end
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output adcStrobes_t strobes,
  output logic        validOut
);
  logic pendQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ    <= 1'b0;
      validOut <= 1'b0;
    end else begin
      pendQ    <= start;
      validOut <= pendQ;
    end
  end

  always_comb begin
    strobes.capture = start;
    strobes.present = pendQ;
  end
endmodule

// File: rtl/adc_datapath.sv
module adc_datapath
  import adc_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  adcStrobes_t                strobes,
  input  logic [DIGITS*DIGIT_W-1:0]  accIn,
  input  logic [DIGITS*DIGIT_W-1:0]  operandIn,
  input  logic                       carryIn,
  input  logic                       decimalIn,
  output logic [DIGITS*DIGIT_W-1:0]  result,
  output adcFlags_t                  flags,
  output logic                       heldDecimal
);
  localparam int DATA_W = DIGITS * DIGIT_W;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] accQ, opQ;
  logic              cinQ, decQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= '0;
      opQ  <= '0;
      cinQ <= 1'b0;
      decQ <= 1'b0;
    end else if (strobes.capture) begin
      accQ <= accIn;
      opQ  <= operandIn;
      cinQ <= carryIn;
      decQ <= decimalIn;
    end
  end

  // binary path
  logic [DATA_W:0]   binFull;
  logic [DATA_W-1:0] binByte;
  assign binFull = {1'b0, accQ} + {1'b0, opQ} + {{DATA_W{1'b0}}, cinQ};
  assign binByte = binFull[DATA_W-1:0];

  // decimal path: chain of digit cells
  logic [DIGITS:0]   chainCarry;
  logic [DATA_W-1:0] decByte;
  logic [DATA_W-1:0] rawDigits;
  assign chainCarry[0] = cinQ;

  genvar d;
  generate
    for (d = 0; d < DIGITS; d++) begin : g_digit
      adc_digit_cell u_cell (
        .digA     (accQ[d*DIGIT_W +: DIGIT_W]),
        .digB     (opQ[d*DIGIT_W +: DIGIT_W]),
        .digCin   (chainCarry[d]),
        .rawLow   (rawDigits[d*DIGIT_W +: DIGIT_W]),
        .adjDigit (decByte[d*DIGIT_W +: DIGIT_W]),
        .digCout  (chainCarry[d+1])
      );
    end
  endgenerate

  logic signsMatch;
  logic binOverflow, decOverflow;
  assign signsMatch  = (accQ[MSB] == opQ[MSB]);
  assign binOverflow = signsMatch && (opQ[MSB] != binByte[MSB]);
  // top digit bit taken before its correction
  assign decOverflow = signsMatch && (opQ[MSB] != rawDigits[MSB]);

  logic [DATA_W-1:0] nextResult;
  adcFlags_t         nextFlags;
  always_comb begin
    nextFlags.zero     = (binByte == '0);
    nextFlags.negative = binByte[MSB];
    if (decQ) begin
      nextResult         = decByte;
      nextFlags.carry    = chainCarry[DIGITS];
      nextFlags.overflow = decOverflow;
    end else begin
      nextResult         = binByte;
      nextFlags.carry    = binFull[DATA_W];
      nextFlags.overflow = binOverflow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      flags       <= '0;
      heldDecimal <= 1'b0;
    end else if (strobes.present) begin
      result      <= nextResult;
      flags       <= nextFlags;
      heldDecimal <= decQ;
    end
  end
endmodule

// File: rtl/dec_adc_unit.sv
module dec_adc_unit
  import adc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] accIn,
  input  logic [7:0] operandIn,
  input  logic       carryIn,
  input  logic       decimalIn,
  output logic [7:0] result,
  output logic       carryOut,
  output logic       overflowOut,
  output logic       zeroOut,
  output logic       negativeOut,
  output logic       validOut
);
  adcStrobes_t strobes;
  adcFlags_t   flags;
  logic        heldDecimal;

  adc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .strobes  (strobes),
    .validOut (validOut)
  );

  adc_datapath #(.DIGITS(2)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .accIn       (accIn),
    .operandIn   (operandIn),
    .carryIn     (carryIn),
    .decimalIn   (decimalIn),
    .result      (result),
    .flags       (flags),
    .heldDecimal (heldDecimal)
  );

  assign carryOut    = flags.carry;
  assign overflowOut = flags.overflow;
  assign zeroOut     = flags.zero;
  assign negativeOut = flags.negative;
endmodule

// File: rtl/dec_adc_unit_chk.sv
module dec_adc_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [7:0] result,
  input logic       carryOut,
  input logic       overflowOut,
  input logic       zeroOut,
  input logic       negativeOut,
  input logic       validOut,
  input logic       heldDecimal
);
  assert_valid_after_start_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> ##1 validOut);

  assert_no_stray_valid_R8: assert property (@(posedge clk) disable iff (rst)
    validOut |-> $past(start, 2));

  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> ($stable(result) && $stable(carryOut) && $stable(overflowOut)
                   && $stable(zeroOut) && $stable(negativeOut)));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (result == 8'h00 && !carryOut && !overflowOut && !zeroOut
             && !negativeOut && !validOut));

  assert_bin_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (validOut && !heldDecimal) |-> (zeroOut == (result == 8'h00)));

  assert_bin_negative_R6: assert property (@(posedge clk) disable iff (rst)
    (validOut && !heldDecimal) |-> (negativeOut == result[7]));
endmodule

bind dec_adc_unit dec_adc_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .result      (result),
  .carryOut    (carryOut),
  .overflowOut (overflowOut),
  .zeroOut     (zeroOut),
  .negativeOut (negativeOut),
  .validOut    (validOut),
  .heldDecimal (heldDecimal)
);

// File: tb/sim_dec_adc_unit.sv
module sim_dec_adc_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] accIn = '0, operandIn = '0;
  logic       carryIn = 1'b0, decimalIn = 1'b0;
  logic [7:0] result;
  logic       carryOut, overflowOut, zeroOut, negativeOut, validOut;

  always #5 clk = ~clk;

  dec_adc_unit u0 (
    .clk(clk), .rst(rst), .start(start), .accIn(accIn), .operandIn(operandIn),
    .carryIn(carryIn), .decimalIn(decimalIn), .result(result),
    .carryOut(carryOut), .overflowOut(overflowOut), .zeroOut(zeroOut),
    .negativeOut(negativeOut), .validOut(validOut)
  );

  typedef struct {
    int  res;
    bit  c, v, z, n, dec;
    int  issued;
  } expItem_t;

  expItem_t sbQueue[$];
  int total = 0;
  int bad = 0;
  int cycleCount = 0;
  bit finished = 0;

  always @(posedge clk) cycleCount <= cycleCount + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic expItem_t refModel(input int a, input int b, input int c, input int d);
    expItem_t e;
    int bin, lo, hi, pre, sa, sb, s;
    bin = a + b + c;
    e.z = ((bin & 255) == 0);
    e.n = ((bin >> 7) & 1) == 1;
    e.dec = (d != 0);
    if (d != 0) begin
      lo = (a & 15) + (b & 15) + c;
      hi = (a >> 4) + (b >> 4);
      if (lo >= 10) begin lo -= 10; hi++; end
      pre = hi & 15;
      e.c = (hi >= 10);
      if (hi >= 10) hi -= 10;
      e.res = ((hi & 15) << 4) | (lo & 15);
      e.v = (((a >> 7) & 1) == ((b >> 7) & 1)) && (((b >> 7) & 1) != ((pre >> 3) & 1));
    end else begin
      e.res = bin & 255;
      e.c = (bin > 255);
      sa = (a >= 128) ? a - 256 : a;
      sb = (b >= 128) ? b - 256 : b;
      s = sa + sb + c;
      e.v = (s < -128) || (s > 127);
    end
    return e;
  endfunction

  // driver: one operation per call, start left high for back-to-back issue
  task automatic drive(input int a, input int b, input int c, input int d);
    expItem_t e;
    @(negedge clk);
    accIn = 8'(a); operandIn = 8'(b); carryIn = c[0]; decimalIn = d[0];
    start = 1'b1;
    e = refModel(a, b, c, d);
    e.issued = cycleCount;
    sbQueue.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    expItem_t e;
    if (!rst && validOut) begin
      if (sbQueue.size() == 0) begin
        check(1'b0, "R8 stray valid", 1, 0);
      end else begin
        e = sbQueue.pop_front();
        check(cycleCount - e.issued == 2, "R8 latency", cycleCount - e.issued, 2);
        if (e.dec) begin
          check(result[3:0] == 4'(e.res), "R3 low digit", result, e.res);
          check(result[7:4] == 4'(e.res >> 4), "R4 high digit", result, e.res);
          check(carryOut == e.c, "R4 carry", carryOut, e.c);
          check(overflowOut == e.v, "R5 overflow", overflowOut, e.v);
        end else begin
          check(result == 8'(e.res), "R1 sum", result, e.res);
          check(carryOut == e.c, "R1 carry", carryOut, e.c);
          check(overflowOut == e.v, "R2 overflow", overflowOut, e.v);
        end
        check(zeroOut == e.z, "R6 zero", zeroOut, e.z);
        check(negativeOut == e.n, "R6 negative", negativeOut, e.n);
      end
    end
  end

  task automatic drain();
    while (sbQueue.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=done", cycleCount);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] heldRes;
    repeat (3) @(negedge clk);
    // R10: outputs cleared under reset
    check(result == 0 && !carryOut && !overflowOut && !zeroOut && !negativeOut && !validOut,
          "R10 reset state", {result, carryOut, overflowOut, zeroOut, negativeOut}, 0);
    rst = 1'b0;
    idle(2);
    check(validOut == 1'b0, "R8 idle no valid", validOut, 0);

    // directed corners (R3 R4 R5)
    drive(8'h99, 8'h01, 0, 1);   // 00, carry
    drive(8'h58, 8'h46, 1, 1);   // 05, carry
    drive(8'h79, 8'h00, 1, 1);   // 80, V set from pre-adjust high digit
    drive(8'h7F, 8'h01, 0, 0);   // binary overflow R2
    drive(8'hFF, 8'h01, 0, 0);   // binary zero+carry R1 R6
    drive(8'hFF, 8'hFF, 1, 1);   // R7 non-BCD digits
    idle(3);
    drain();

    // R9: inputs change without start, outputs hold
    heldRes = result;
    @(negedge clk);
    accIn = 8'h12; operandIn = 8'h34; carryIn = 1'b1; decimalIn = 1'b0;
    idle(4);
    check(result == heldRes, "R9 hold result", result, heldRes);
    check(validOut == 1'b0, "R9 no valid", validOut, 0);

    // R7: every operand pair, mode/carry rotating over the four combinations
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        drive(a, b, (a + b) & 1, ((a + b) >> 1) & 1);
      end
    end
    idle(1);
    drain();

    // strided sweep over all four mode/carry combinations
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 256; a += 5) begin
        for (int b = 0; b < 256; b += 3) begin
          drive(a, b, m & 1, m >> 1);
        end
      end
    end
    idle(1);
    drain();

    // R10: mid-run reset clears a nonzero result
    drive(8'h40, 8'h40, 0, 0);
    idle(3);
    drain();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(result == 0 && !overflowOut && !negativeOut && !validOut,
          "R10 mid-run reset", {result, overflowOut, negativeOut}, 0);
    rst = 1'b0;
    idle(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule